// File: doc/BRIEF.md
# Four-Channel Byte-Programmed DMA Controller

This block is a register-programmed DMA controller with four channels. A host reaches its registers through an 8-bit port with chip select, a 4-bit offset and one-cycle read and write strobes. Each channel holds a 16-bit address and a 16-bit count, an 8-bit page that forms the upper address bits, and a small mode word. All the 16-bit registers share one byte pointer, so the host loads or reads each of them as two byte accesses, low byte first.

A peripheral raises its request line. The controller grants the lowest-numbered eligible channel with a one-cycle acknowledge and drives a 24-bit memory address and a direction strobe during that cycle. After each acknowledge the channel steps its address up and its count down. The controller moves no data itself. When a step happens with a count of zero, that is terminal count: the channel records it in the status register and then either masks itself or reloads its starting values. A build parameter chooses byte or word addressing.

Top module: `dmac_legacy4`

## Requirements
- R1: Offsets 0x0 to 0x7 are the channel registers. Channel n has its address at offset 2n and its count at offset 2n+1. Each access goes through a single byte pointer that is shared by all channels and starts at the low byte. The pointer flips after every read or write to any of these eight offsets. A write updates both the starting value and the current value.
- R2: A write of any value to offset 0xE returns the byte pointer to the low byte.
- R3: A programmed count of N gives exactly N+1 acknowledges. The last of them raises `term_cnt`. Each acknowledge adds one to the current address and subtracts one from the current count. Reads at offsets 0x0 to 0x7 return the current values.
- R4: A write to offset 0xD sets the mode of the channel named by bits [1:0]. Bits [3:2] give the direction: 01 raises `mem_wr` during acknowledges and 10 raises `mem_rd`. Bit 4 enables auto-reload. A channel whose direction is 00 or 11 is never acknowledged.
- R5: All channels are masked after reset. A write to offset 0xC with bit 2 clear unmasks the channel named by bits [1:0], and a write with bit 2 set masks it. A masked channel is never acknowledged.
- R6: A read of offset 0xC returns terminal-count flags for channels 0 to 3 in bits [3:0]. The read clears the flags.
- R7: Offsets 0x8 to 0xB hold the pages of channels 0 to 3 and can be read back. The page gives `mem_addr[23:16]` and is never changed by a transfer, so the address wraps from 0xFFFF to 0x0000 inside its page.
- R8: With `WORD_ADDR` = 1, `mem_addr` is the page followed by the current address shifted left by one bit. The 16-bit registers then count in words.
- R9: At terminal count, a channel with auto-reload restores its starting address and count and stays unmasked. A channel without auto-reload sets its own mask bit.
- R10: A write to offset 0xF resets the byte pointer, clears all status flags and masks all four channels.
- R11: If several unmasked channels with a valid direction request at once, the lowest-numbered one is acknowledged. The acknowledge is one-hot and lasts one cycle, and at least one idle cycle follows each acknowledge.
- R12: Read data appears on `rdata` in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Host chip select |
| wr | input | 1 | Host write strobe, one cycle |
| rd | input | 1 | Host read strobe, one cycle |
| offset | input | 4 | Register offset |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, registered |
| dreq | input | 4 | Per-channel transfer request |
| dack | output | 4 | Per-channel acknowledge, one-hot |
| mem_addr | output | 24 | Memory address during an acknowledge |
| mem_wr | output | 1 | Acknowledged transfer writes memory |
| mem_rd | output | 1 | Acknowledged transfer reads memory |
| term_cnt | output | 1 | Acknowledged transfer reaches terminal count |

## Verification
The assertions check the following on every cycle:
- the acknowledge is one-hot and is always followed by an idle cycle;
- an acknowledge goes only to a channel that was eligible one cycle earlier, and never while a lower-numbered channel was eligible;
- a direction strobe is raised only during an acknowledge;
- terminal count sets the channel's status flag, and sets its mask unless auto-reload is on;
- master clear masks every channel;
- word-mode addresses are even.

Other behaviour needs the bench's scenarios:
- the low-then-high byte ordering and pointer reset;
- the exact number of acknowledges for a programmed count and the address sequence they produce;
- wrapping inside a page;
- reload of the starting values;
- read-to-clear status and read-back of the current address and count.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int NCH  = 4;              // channels
    localparam int CHW  = $clog2(NCH);    // channel index width
    localparam int DW   = 8;              // host data width
    localparam int RW   = 2 * DW;         // address / count register width
    localparam int PW   = DW;             // page width
    localparam int AW   = RW + PW;        // memory address width
    localparam int OFFW = CHW + 2;        // host offset width

    localparam logic [RW-1:0]       RW_ONE     = RW'(1);
    localparam logic [CHW-1:0]      PAGE_GRP   = CHW'(2);   // offset[3:2] == 2'b10
    localparam logic [OFFW-1:0]     OFF_STAT   = OFFW'(12); // read status / write mask
    localparam logic [OFFW-1:0]     OFF_MODE   = OFFW'(13);
    localparam logic [OFFW-1:0]     OFF_CLRPTR = OFFW'(14);
    localparam logic [OFFW-1:0]     OFF_MCLR   = OFFW'(15);
    localparam int                  MASK_SET_BIT = 2;
    localparam int                  AUTO_BIT     = 4;

    typedef enum logic [1:0] {
        DIR_NONE    = 2'b00,
        DIR_TOMEM   = 2'b01,
        DIR_FROMMEM = 2'b10,
        DIR_BAD     = 2'b11
    } dir_e;

    typedef struct packed {
        dir_e dir;
        logic autoinit;
    } chmode_t;

    typedef struct packed {
        logic addr_lo;
        logic addr_hi;
        logic cnt_lo;
        logic cnt_hi;
    } ldsel_t;

    function automatic logic [AW-1:0] form_addr(
        input logic [PW-1:0] page,
        input logic [RW-1:0] a,
        input logic          word
    );
        if (word) return {page, a[RW-2:0], 1'b0};
        return {page, a};
    endfunction

    function automatic logic [DW-1:0] pick_byte(input logic [RW-1:0] v, input logic hi);
        return hi ? v[RW-1:DW] : v[DW-1:0];
    endfunction

    function automatic logic dir_valid(input dir_e d);
        return (d == DIR_TOMEM) || (d == DIR_FROMMEM);
    endfunction

endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  ldsel_t        ld,
    input  logic [DW-1:0] wdata,
    input  logic          step,
    input  logic          autoinit,
    output logic [RW-1:0] cur_addr,
    output logic [RW-1:0] cur_cnt,
    output logic          tc_evt
);
    logic [RW-1:0] base_addr, base_cnt;
    logic [RW-1:0] addr_n, cnt_n, baddr_n, bcnt_n;

    assign tc_evt = step && (cur_cnt == '0);

    always_comb begin
        baddr_n = base_addr;
        bcnt_n  = base_cnt;
        addr_n  = cur_addr;
        cnt_n   = cur_cnt;
        if (step) begin
            if (tc_evt && autoinit) begin
                addr_n = base_addr;
                cnt_n  = base_cnt;
            end else begin
                addr_n = cur_addr + RW_ONE;
                cnt_n  = cur_cnt - RW_ONE;
            end
        end
        // host load of a byte overrides the stepped value of that byte
        if (ld.addr_lo) begin baddr_n[DW-1:0]  = wdata; addr_n[DW-1:0]  = wdata; end
        if (ld.addr_hi) begin baddr_n[RW-1:DW] = wdata; addr_n[RW-1:DW] = wdata; end
        if (ld.cnt_lo)  begin bcnt_n[DW-1:0]   = wdata; cnt_n[DW-1:0]   = wdata; end
        if (ld.cnt_hi)  begin bcnt_n[RW-1:DW]  = wdata; cnt_n[RW-1:DW]  = wdata; end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
        end else begin
            base_addr <= baddr_n;
            base_cnt  <= bcnt_n;
            cur_addr  <= addr_n;
            cur_cnt   <= cnt_n;
        end
    end

endmodule

// File: rtl/dmac_arb.sv
module dmac_arb
    import dmac_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] elig,
    output logic [NCH-1:0] grant
);
    logic [NCH-1:0] pick;

    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < NCH; i++) begin
            if (elig[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              grant <= '0;
        else if (grant != '0) grant <= '0;   // idle cycle after every acknowledge
        else                  grant <= pick;
    end

endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cs,
    input  logic                    wr,
    input  logic                    rd,
    input  logic [OFFW-1:0]         offset,
    input  logic [DW-1:0]           wdata,
    input  logic [NCH-1:0][RW-1:0]  cur_addr,
    input  logic [NCH-1:0][RW-1:0]  cur_cnt,
    input  logic [NCH-1:0]          tc_evt,
    output logic [DW-1:0]           rdata,
    output ldsel_t [NCH-1:0]        ld,
    output logic [NCH-1:0]          mask,
    output logic [NCH-1:0]          status,
    output logic [NCH-1:0][PW-1:0]  page,
    output chmode_t [NCH-1:0]       chmode
);
    logic           ptr;
    logic           host_wr, host_rd, is_chan, ch_acc;
    logic [CHW-1:0] sel_ch;
    logic           sel_cnt;
    logic           wr_mask, wr_mode, wr_clrptr, wr_mclr, wr_page, rd_stat;
    logic [NCH-1:0] mask_n, stat_n;
    logic [DW-1:0]  rd_val;

    assign host_wr   = cs && wr;
    assign host_rd   = cs && rd;
    assign is_chan   = !offset[OFFW-1];
    assign sel_ch    = offset[CHW:1];
    assign sel_cnt   = offset[0];
    assign ch_acc    = is_chan && (host_wr || host_rd);
    assign wr_page   = host_wr && (offset[OFFW-1:CHW] == PAGE_GRP);
    assign wr_mask   = host_wr && (offset == OFF_STAT);
    assign wr_mode   = host_wr && (offset == OFF_MODE);
    assign wr_clrptr = host_wr && (offset == OFF_CLRPTR);
    assign wr_mclr   = host_wr && (offset == OFF_MCLR);
    assign rd_stat   = host_rd && (offset == OFF_STAT);

    // byte pointer shared by all address/count registers
    always_ff @(posedge clk) begin
        if (rst)                       ptr <= 1'b0;
        else if (wr_clrptr || wr_mclr) ptr <= 1'b0;
        else if (ch_acc)               ptr <= !ptr;
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ld[i] = '0;
            if (host_wr && is_chan && (sel_ch == CHW'(i))) begin
                ld[i].addr_lo = !sel_cnt && !ptr;
                ld[i].addr_hi = !sel_cnt &&  ptr;
                ld[i].cnt_lo  =  sel_cnt && !ptr;
                ld[i].cnt_hi  =  sel_cnt &&  ptr;
            end
        end
    end

    always_comb begin
        mask_n = mask;
        for (int i = 0; i < NCH; i++)
            if (tc_evt[i] && !chmode[i].autoinit) mask_n[i] = 1'b1;
        if (wr_mask) mask_n[wdata[CHW-1:0]] = wdata[MASK_SET_BIT];
        if (wr_mclr) mask_n = '1;
    end

    always_comb begin
        stat_n = status;
        if (rd_stat) stat_n = '0;
        stat_n = stat_n | tc_evt;
        if (wr_mclr) stat_n = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask   <= '1;
            status <= '0;
        end else begin
            mask   <= mask_n;
            status <= stat_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page   <= '0;
            chmode <= '0;
        end else begin
            if (wr_page) page[offset[CHW-1:0]] <= wdata;
            if (wr_mode) begin
                chmode[wdata[CHW-1:0]].dir      <= dir_e'(wdata[CHW+1:CHW]);
                chmode[wdata[CHW-1:0]].autoinit <= wdata[AUTO_BIT];
            end
        end
    end

    always_comb begin
        rd_val = '0;
        if (is_chan)
            rd_val = pick_byte(sel_cnt ? cur_cnt[sel_ch] : cur_addr[sel_ch], ptr);
        else if (offset[OFFW-1:CHW] == PAGE_GRP)
            rd_val = page[offset[CHW-1:0]];
        else if (offset == OFF_STAT)
            rd_val = {{(DW-NCH){1'b0}}, status};
    end

    always_ff @(posedge clk) begin
        if (rst)          rdata <= '0;
        else if (host_rd) rdata <= rd_val;
    end

endmodule

// File: rtl/dmac_legacy4.sv
module dmac_legacy4
    import dmac_pkg::*;
#(
    parameter bit WORD_ADDR = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs,
    input  logic            wr,
    input  logic            rd,
    input  logic [OFFW-1:0] offset,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [NCH-1:0]  dreq,
    output logic [NCH-1:0]  dack,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_wr,
    output logic            mem_rd,
    output logic            term_cnt
);
    logic [NCH-1:0][RW-1:0] cur_addr, cur_cnt;
    logic [NCH-1:0]         tc_evt;
    ldsel_t [NCH-1:0]       ld;
    logic [NCH-1:0]         chan_mask, chan_stat, chan_auto, chan_elig;
    logic [NCH-1:0][PW-1:0] page;
    chmode_t [NCH-1:0]      chmode;

    dmac_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cs       (cs),
        .wr       (wr),
        .rd       (rd),
        .offset   (offset),
        .wdata    (wdata),
        .cur_addr (cur_addr),
        .cur_cnt  (cur_cnt),
        .tc_evt   (tc_evt),
        .rdata    (rdata),
        .ld       (ld),
        .mask     (chan_mask),
        .status   (chan_stat),
        .page     (page),
        .chmode   (chmode)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dmac_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .ld       (ld[g]),
            .wdata    (wdata),
            .step     (dack[g]),
            .autoinit (chmode[g].autoinit),
            .cur_addr (cur_addr[g]),
            .cur_cnt  (cur_cnt[g]),
            .tc_evt   (tc_evt[g])
        );
        assign chan_auto[g] = chmode[g].autoinit;
        assign chan_elig[g] = dreq[g] && !chan_mask[g] && dir_valid(chmode[g].dir);
    end

    dmac_arb u_arb (
        .clk   (clk),
        .rst   (rst),
        .elig  (chan_elig),
        .grant (dack)
    );

    always_comb begin
        mem_addr = '0;
        mem_wr   = 1'b0;
        mem_rd   = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (dack[i]) begin
                mem_addr = form_addr(page[i], cur_addr[i], WORD_ADDR);
                mem_wr   = (chmode[i].dir == DIR_TOMEM);
                mem_rd   = (chmode[i].dir == DIR_FROMMEM);
            end
        end
    end

    assign term_cnt = |tc_evt;

endmodule

// File: rtl/dmac_legacy4_chk.sv
module dmac_legacy4_chk
    import dmac_pkg::*;
#(
    parameter bit WORD_ADDR = 1'b0
) (
    input logic            clk,
    input logic            rst,
    input logic            cs,
    input logic            wr,
    input logic [OFFW-1:0] offset,
    input logic [NCH-1:0]  dack,
    input logic [AW-1:0]   mem_addr,
    input logic            mem_wr,
    input logic            mem_rd,
    input logic            term_cnt,
    input logic [NCH-1:0]  chan_mask,
    input logic [NCH-1:0]  chan_stat,
    input logic [NCH-1:0]  chan_auto,
    input logic [NCH-1:0]  chan_elig
);
    localparam logic [NCH-1:0] ONE_N = NCH'(1);

    a_r11_onehot_ack: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    a_r11_idle_after_ack: assert property (@(posedge clk) disable iff (rst)
        (dack != '0) |=> (dack == '0));

    a_r11_ack_was_eligible: assert property (@(posedge clk) disable iff (rst)
        (dack != '0) |-> (($past(chan_elig) & dack) == dack));

    a_r11_lowest_first: assert property (@(posedge clk) disable iff (rst)
        (dack != '0) |-> (($past(chan_elig) & (dack - ONE_N)) == '0));

    a_r4_dir_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr && mem_rd));

    a_r4_dir_only_on_ack: assert property (@(posedge clk) disable iff (rst)
        (mem_wr || mem_rd) |-> (dack != '0));

    a_r3_tc_only_on_ack: assert property (@(posedge clk) disable iff (rst)
        term_cnt |-> (dack != '0));

    a_r6_tc_sets_status: assert property (@(posedge clk) disable iff (rst)
        (term_cnt && !(cs && wr && offset == OFF_MCLR)) |=>
            ((chan_stat & $past(dack)) == $past(dack)));

    a_r9_tc_masks_plain: assert property (@(posedge clk) disable iff (rst)
        (term_cnt && !(cs && wr)) |=>
            ((chan_mask & $past(dack) & ~$past(chan_auto)) == ($past(dack) & ~$past(chan_auto))));

    a_r10_mclr_masks_all: assert property (@(posedge clk) disable iff (rst)
        (cs && wr && offset == OFF_MCLR) |=> ((chan_mask == '1) && (chan_stat == '0)));

    if (WORD_ADDR) begin : g_word
        a_r8_word_even: assert property (@(posedge clk) disable iff (rst)
            (dack != '0) |-> !mem_addr[0]);
    end

endmodule

bind dmac_legacy4 dmac_legacy4_chk #(.WORD_ADDR(WORD_ADDR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs        (cs),
    .wr        (wr),
    .offset    (offset),
    .dack      (dack),
    .mem_addr  (mem_addr),
    .mem_wr    (mem_wr),
    .mem_rd    (mem_rd),
    .term_cnt  (term_cnt),
    .chan_mask (chan_mask),
    .chan_stat (chan_stat),
    .chan_auto (chan_auto),
    .chan_elig (chan_elig)
);

// File: tb/dmac_legacy4_bench.sv
`timescale 1ns/1ps
module dmac_legacy4_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [3:0]  offset = '0;
    logic [7:0]  wdata = '0;
    logic [3:0]  dreq = '0;
    logic [7:0]  rdata, w_rdata;
    logic [3:0]  dack, w_dack;
    logic [23:0] mem_addr, w_mem_addr;
    logic        mem_wr, mem_rd, term_cnt, w_mem_wr, w_mem_rd, w_tc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dmac_legacy4 #(.WORD_ADDR(1'b0)) u_dmac_legacy4 (
        .clk(clk), .rst(rst), .cs(cs), .wr(wr), .rd(rd), .offset(offset), .wdata(wdata),
        .rdata(rdata), .dreq(dreq), .dack(dack), .mem_addr(mem_addr),
        .mem_wr(mem_wr), .mem_rd(mem_rd), .term_cnt(term_cnt));

    dmac_legacy4 #(.WORD_ADDR(1'b1)) u_dmac_legacy4_word (
        .clk(clk), .rst(rst), .cs(cs), .wr(wr), .rd(rd), .offset(offset), .wdata(wdata),
        .rdata(w_rdata), .dreq(dreq), .dack(w_dack), .mem_addr(w_mem_addr),
        .mem_wr(w_mem_wr), .mem_rd(w_mem_rd), .term_cnt(w_tc));

    // {op, offset, data, expected}: op 0 = write, op 1 = read and compare
    localparam int NV = 20;
    localparam logic [21:0] VEC [NV] = '{
        {2'd0, 4'hE, 8'h00, 8'h00},
        {2'd0, 4'h2, 8'h34, 8'h00},
        {2'd0, 4'h2, 8'h12, 8'h00},
        {2'd0, 4'h3, 8'h02, 8'h00},
        {2'd0, 4'h3, 8'h00, 8'h00},
        {2'd1, 4'h2, 8'h00, 8'h34},
        {2'd1, 4'h2, 8'h00, 8'h12},
        {2'd1, 4'h3, 8'h00, 8'h02},
        {2'd1, 4'h3, 8'h00, 8'h00},
        {2'd0, 4'h4, 8'hAA, 8'h00},
        {2'd0, 4'hE, 8'h00, 8'h00},
        {2'd1, 4'h4, 8'h00, 8'hAA},
        {2'd0, 4'hE, 8'h00, 8'h00},
        {2'd0, 4'h9, 8'h5A, 8'h00},
        {2'd1, 4'h9, 8'h00, 8'h5A},
        {2'd1, 4'hC, 8'h00, 8'h00},
        {2'd0, 4'h4, 8'hBB, 8'h00},
        {2'd0, 4'h4, 8'hCC, 8'h00},
        {2'd1, 4'h4, 8'h00, 8'hBB},
        {2'd1, 4'h4, 8'h00, 8'hCC}
    };

    logic [3:0]  ack_ch   [16];
    logic [23:0] ack_addr [16];
    logic [23:0] ack_waddr[16];
    logic        ack_wr   [16];
    logic        ack_rd   [16];
    logic        ack_tc   [16];
    int          n_ack;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [3:0] off, input logic [7:0] d);
        cs = 1'b1; wr = 1'b1; offset = off; wdata = d;
        @(posedge clk); #1;
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic host_rd(input logic [3:0] off, output logic [7:0] d);
        cs = 1'b1; rd = 1'b1; offset = off;
        @(posedge clk); #1;
        cs = 1'b0; rd = 1'b0;
        d = rdata;   // R12: valid the cycle after the strobe
    endtask

    task automatic prog16(input logic [3:0] off, input logic [15:0] v);
        host_wr(off, v[7:0]);
        host_wr(off, v[15:8]);
    endtask

    task automatic collect(input int cycles);
        n_ack = 0;
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk); #1;
            if (dack != 4'd0 && n_ack < 16) begin
                ack_ch[n_ack]    = dack;
                ack_addr[n_ack]  = mem_addr;
                ack_waddr[n_ack] = w_mem_addr;
                ack_wr[n_ack]    = mem_wr;
                ack_rd[n_ack]    = mem_rd;
                ack_tc[n_ack]    = term_cnt;
                n_ack++;
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;

        // reset state (R5, R12)
        chk("R5 reset dack", dack, 4'd0);
        chk("R12 reset rdata", rdata, 8'h00);
        chk("R4 reset mem_wr", mem_wr, 1'b0);
        chk("R3 reset term_cnt", term_cnt, 1'b0);

        // host register table (R1, R2, R6, R7)
        for (int v = 0; v < NV; v++) begin
            logic [21:0] e;
            string tag;
            e = VEC[v];
            case (e[19:16])
                4'hE: tag = "R2 table";
                4'hC: tag = "R6 table";
                4'h8, 4'h9, 4'hA, 4'hB: tag = "R7 table";
                default: tag = "R1 table";
            endcase
            if (e[21:20] == 2'd0) host_wr(e[19:16], e[15:8]);
            else begin
                host_rd(e[19:16], r);
                chk($sformatf("%s vec %0d", tag, v), r, e[7:0]);
            end
        end

        // Test A: ch1, addr 0x1234, count 2, page 0x5A, to memory
        host_wr(4'hD, 8'h45);
        dreq = 4'b0010;
        collect(6);
        chk("R5 masked channel not acked", n_ack, 0);
        host_wr(4'hC, 8'h01);
        collect(12);
        dreq = 4'b0000;
        chk("R3 ack count N+1", n_ack, 3);
        for (int k = 0; k < 3; k++) begin
            chk($sformatf("R11 ack ch1 #%0d", k), ack_ch[k], 4'b0010);
            chk($sformatf("R7 addr #%0d", k), ack_addr[k], 24'h5A1234 + k);
            chk($sformatf("R8 word addr #%0d", k), ack_waddr[k], 24'h5A2468 + 2 * k);
            chk($sformatf("R4 mem_wr #%0d", k), {ack_wr[k], ack_rd[k]}, 2'b10);
            chk($sformatf("R3 tc #%0d", k), ack_tc[k], (k == 2));
        end
        host_rd(4'hC, r); chk("R6 status ch1", r, 8'h02);
        host_rd(4'hC, r); chk("R6 status cleared", r, 8'h00);
        host_rd(4'h2, r); chk("R3 cur addr lo", r, 8'h37);
        host_rd(4'h2, r); chk("R3 cur addr hi", r, 8'h12);
        host_rd(4'h3, r); chk("R3 cur cnt lo", r, 8'hFF);
        host_rd(4'h3, r); chk("R3 cur cnt hi", r, 8'hFF);
        dreq = 4'b0010;
        collect(6);
        dreq = 4'b0000;
        chk("R9 plain channel masked after tc", n_ack, 0);

        // Test B: priority, from memory, page wrap
        prog16(4'h0, 16'h0100); prog16(4'h1, 16'h0000);
        prog16(4'h4, 16'hFFFF); prog16(4'h5, 16'h0001);
        host_wr(4'hA, 8'h33);
        host_wr(4'hD, 8'h48); host_wr(4'hD, 8'h4A);
        host_wr(4'hC, 8'h00); host_wr(4'hC, 8'h02);
        dreq = 4'b0101;
        collect(12);
        dreq = 4'b0000;
        chk("R11 three acks", n_ack, 3);
        chk("R11 lowest first", ack_ch[0], 4'b0001);
        chk("R11 then ch2", ack_ch[1], 4'b0100);
        chk("R4 mem_rd", {ack_wr[0], ack_rd[0]}, 2'b01);
        chk("R7 ch0 addr", ack_addr[0], 24'h000100);
        chk("R7 before wrap", ack_addr[1], 24'h33FFFF);
        chk("R7 wrap in page", ack_addr[2], 24'h330000);
        chk("R8 word wrap", ack_waddr[2], 24'h330000);
        chk("R8 word before wrap", ack_waddr[1], 24'h33FFFE);
        host_rd(4'hC, r); chk("R6 status ch0 ch2", r, 8'h05);

        // Test C: ch3 auto-reload
        prog16(4'h6, 16'h2000); prog16(4'h7, 16'h0001);
        host_wr(4'hB, 8'h10);
        host_wr(4'hD, 8'h57);
        host_wr(4'hC, 8'h03);
        dreq = 4'b1000;
        collect(12);
        dreq = 4'b0000;
        chk("R9 keeps running", n_ack, 6);
        chk("R9 reload addr", ack_addr[2], 24'h102000);
        chk("R9 second tc", {ack_tc[1], ack_tc[2], ack_tc[3]}, 3'b101);

        // Test D: master clear
        host_wr(4'h0, 8'h77);
        host_wr(4'hF, 8'h00);
        host_rd(4'h0, r); chk("R10 pointer reset", r, 8'h77);
        host_rd(4'hC, r); chk("R10 status cleared", r, 8'h00);
        dreq = 4'b1000;
        collect(8);
        dreq = 4'b0000;
        chk("R10 all masked", n_ack, 0);

        // Test E: invalid direction never granted
        host_wr(4'hD, 8'h40);
        host_wr(4'hC, 8'h00);
        dreq = 4'b0001;
        collect(8);
        dreq = 4'b0000;
        chk("R4 invalid direction", n_ack, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule